// File: doc/BRIEF.md
# I2C Receive Byte Readout with First-Byte Marking

This block sits between an I2C bus engine and a host register bus. It covers the receive side only. The bus engine hands over each received byte with a one-cycle strobe, and it pulses a separate input when an address phase has finished. The block stores every accepted byte in a small FIFO. Each entry also carries one mark bit. The mark is set when the byte is the first one stored after an address phase. The same rule applies whether the engine is acting as a master receiver or a slave receiver.

The host reads the FIFO through a single data register. On a 32-bit host bus, one read at byte offset 0 pops an entry. That read returns the data byte in the low eight bits and the mark in bit 11. On an 8-bit host bus the read is split in two:

- A read at offset 0 pops an entry and returns the data byte.
- A later read at offset 1 returns a held copy of the popped byte's mark. This second read is optional, and skipping it changes nothing else.

A read from an empty FIFO returns zero, pops nothing and sets a sticky underflow flag.

Top module: `i2c_rx_readout`

## Requirements
- R1: The FIFO holds up to DEPTH bytes and returns them in arrival order. A byte strobed in while the FIFO is full is discarded, even if a pop happens in the same cycle.
- R2: The mark of a stored byte is 1 when it is the first byte stored since the last address-done pulse. This includes a byte strobed in the same cycle as that pulse. Every later byte gets mark 0. After reset the mark is 0 until the first address-done pulse.
- R3: With HOST_W=32, a read at offset 0 pops one entry. It returns the data in bits 7:0 and the mark in bit 11 when TAG_EN=1. Bits 31:12 and 10:8 read as 0. Reads at offsets 1 to 3 return 0 and do not pop.
- R4: With TAG_EN=0, bit 11 (HOST_W=32) or bit 3 of an offset-1 read (HOST_W=8) always reads 0. Only the data byte is returned.
- R5: With HOST_W=8, a read at offset 0 pops one entry and returns its data byte.
- R6: With HOST_W=8, a read at offset 1 returns the held mark of the most recently popped byte in bit 3, with all other bits 0. It does not pop. The held mark changes only on a pop. Offsets 2 and 3 return 0 and do not pop.
- R7: With HOST_W=8, leaving out the offset-1 read between two offset-0 reads does not change the data the second read returns.
- R8: A popping read of an empty FIFO returns 0 and does not pop. It sets the underflow output, which stays 1 until reset.
- R9: Read data appears on rd_data in the cycle after rd_en. It holds until the next read. rd_data and underflow are 0 after reset.
- R10: A byte strobe and a popping read in the same cycle on a FIFO that is not full both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe from the bus engine |
| rx_byte | input | 8 | Received byte |
| addr_done | input | 1 | Pulse marking the end of an address phase |
| rd_en | input | 1 | Host read strobe |
| rd_ofs | input | 2 | Byte offset of the host read |
| rd_data | output | HOST_W | Registered read data |
| underflow | output | 1 | Sticky flag set by a popping read of an empty FIFO |

## Verification
The bench builds three copies of the block with DEPTH=4:

- an 8-bit host bus with marking enabled;
- a 32-bit host bus with marking enabled;
- a 32-bit host bus with marking disabled.

All three receive the same byte stream. This exposes the split two-read access, the single-word access and the mark suppression side by side. The small depth makes the full-FIFO drop and the empty-read underflow reachable within a few strobes. The same-cycle address pulse case and the same-cycle push/pop case are each driven once.

// File: rtl/rxtag_pkg.sv
package rxtag_pkg;
  typedef struct packed {
    logic       first;
    logic [7:0] data;
  } rx_entry_t;

  localparam int unsigned WIDE_TAG_BIT = 11;
endpackage

// File: rtl/rxtag_marker.sv
module rxtag_marker (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_done,
  input  logic stored,
  output logic tag_now,
  output logic pending
);
  logic pend_q, pend_d;

  assign tag_now = pend_q | addr_done;
  assign pending = pend_q;

  always_comb begin
    pend_d = pend_q;
    if (stored) begin
      pend_d = 1'b0;
    end else if (addr_done) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/rxtag_fifo.sv
module rxtag_fifo
  import rxtag_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  rx_entry_t                    push_entry,
  input  logic                         pop,
  output rx_entry_t                    head,
  output logic                         push_ok,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  rx_entry_t     mem_q [DEPTH];
  logic          do_pop;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) begin
      return '0;
    end
    return p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign push_ok = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem_q[rd_q];
  assign count   = cnt_q;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q + CW'(push_ok) - CW'(do_pop);
    if (push_ok) begin
      wr_d = ptr_next(wr_q);
    end
    if (do_pop) begin
      rd_d = ptr_next(rd_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem_q[wr_q] <= push_entry;
    end
  end
endmodule

// File: rtl/rxtag_readport.sv
module rxtag_readport
  import rxtag_pkg::*;
#(
  parameter int unsigned HOST_W = 32,
  parameter bit          TAG_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [1:0]        rd_ofs,
  input  logic              empty,
  input  rx_entry_t         head,
  output logic              pop,
  output logic [HOST_W-1:0] rd_data,
  output logic              underflow
);
  logic              want_pop;
  logic [HOST_W-1:0] rd_val;
  logic [HOST_W-1:0] data_q, data_d;
  logic              uf_q, uf_d;

  generate
    if (HOST_W == 8) begin : g_narrow
      logic held_q, held_d;

      always_comb begin
        want_pop = rd_en && (rd_ofs == 2'd0);
        held_d   = held_q;
        if (want_pop && !empty) begin
          held_d = head.first & TAG_EN;
        end
        case (rd_ofs)
          2'd0:    rd_val = empty ? 8'h00 : head.data;
          2'd1:    rd_val = {4'b0000, held_q, 3'b000};
          default: rd_val = 8'h00;
        endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          held_q <= 1'b0;
        end else begin
          held_q <= held_d;
        end
      end
    end else begin : g_wide
      always_comb begin
        want_pop = rd_en && (rd_ofs == 2'd0);
        rd_val   = '0;
        if (want_pop && !empty) begin
          rd_val[7:0]          = head.data;
          rd_val[WIDE_TAG_BIT] = head.first & TAG_EN;
        end
      end
    end
  endgenerate

  always_comb begin
    pop    = want_pop && !empty;
    uf_d   = uf_q | (want_pop && empty);
    data_d = rd_en ? rd_val : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      uf_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      uf_q   <= uf_d;
    end
  end

  assign rd_data   = data_q;
  assign underflow = uf_q;
endmodule

// File: rtl/i2c_rx_readout.sv
module i2c_rx_readout
  import rxtag_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned HOST_W = 32,
  parameter bit          TAG_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              addr_done,
  input  logic              rd_en,
  input  logic [1:0]        rd_ofs,
  output logic [HOST_W-1:0] rd_data,
  output logic              underflow
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  rx_entry_t       push_entry, head;
  logic            push_ok, empty, full, pop, tag_now, pending;
  logic [CW-1:0]   count;

  assign push_entry.first = tag_now;
  assign push_entry.data  = rx_byte;

  rxtag_marker u_mark (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_done (addr_done),
    .stored    (push_ok),
    .tag_now   (tag_now),
    .pending   (pending)
  );

  rxtag_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (rx_valid),
    .push_entry (push_entry),
    .pop        (pop),
    .head       (head),
    .push_ok    (push_ok),
    .empty      (empty),
    .full       (full),
    .count      (count)
  );

  rxtag_readport #(.HOST_W(HOST_W), .TAG_EN(TAG_EN)) u_rport (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_ofs    (rd_ofs),
    .empty     (empty),
    .head      (head),
    .pop       (pop),
    .rd_data   (rd_data),
    .underflow (underflow)
  );
endmodule

// File: rtl/i2c_rx_readout_chk.sv
module i2c_rx_readout_chk #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned HOST_W = 32,
  parameter bit          TAG_EN = 1'b1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       addr_done,
  input logic                       rd_en,
  input logic [1:0]                 rd_ofs,
  input logic [HOST_W-1:0]          rd_data,
  input logic                       underflow,
  input logic                       push_ok,
  input logic                       pending,
  input logic                       pop,
  input logic                       empty,
  input logic                       full,
  input logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (count <= CW'(DEPTH)) && (full == (count == CW'(DEPTH))));

  assert_no_push_when_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push_ok);

  assert_pending_after_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !push_ok) |=> pending);

  assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty));

  assert_underflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  assert_data_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  assert_pop_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_ofs == 2'd0 && !empty) |-> pop);

  generate
    if (HOST_W == 8) begin : g_narrow_chk
      assert_ofs_no_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_ofs != 2'd0) |-> !pop);
    end else begin : g_wide_chk
      assert_zero_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[HOST_W-1:12] == '0) && (rd_data[10:8] == 3'b000));
      if (!TAG_EN) begin : g_notag
        assert_notag_R4: assert property (@(posedge clk) disable iff (!rst_n)
          rd_data[11] == 1'b0);
      end
    end
  endgenerate
endmodule

bind i2c_rx_readout i2c_rx_readout_chk #(
  .DEPTH(DEPTH), .HOST_W(HOST_W), .TAG_EN(TAG_EN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_done (addr_done),
  .rd_en     (rd_en),
  .rd_ofs    (rd_ofs),
  .rd_data   (rd_data),
  .underflow (underflow),
  .push_ok   (push_ok),
  .pending   (pending),
  .pop       (pop),
  .empty     (empty),
  .full      (full),
  .count     (count)
);

// File: tb/i2c_rx_readout_tb.sv
`timescale 1ns/1ps
module i2c_rx_readout_tb;
  localparam int unsigned DEPTH = 4;

  logic clk, rst_n;
  logic rx_valid, addr_done;
  logic [7:0] rx_byte;
  logic rd_en_a, rd_en_b, rd_en_c;
  logic [1:0] rd_ofs_a;
  logic [7:0] rd_data_a;
  logic [31:0] rd_data_b, rd_data_c;
  logic uf_a, uf_b, uf_c;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [8:0] qa[$], qb[$], qc[$];
  bit pa = 0, pb = 0, pc = 0;
  bit held_a = 0;
  bit ufe_a = 0, ufe_b = 0, ufe_c = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  i2c_rx_readout #(.DEPTH(DEPTH), .HOST_W(8), .TAG_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .addr_done(addr_done), .rd_en(rd_en_a), .rd_ofs(rd_ofs_a),
    .rd_data(rd_data_a), .underflow(uf_a));

  i2c_rx_readout #(.DEPTH(DEPTH), .HOST_W(32), .TAG_EN(1'b1)) u_dut_w (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .addr_done(addr_done), .rd_en(rd_en_b), .rd_ofs(2'd0),
    .rd_data(rd_data_b), .underflow(uf_b));

  i2c_rx_readout #(.DEPTH(DEPTH), .HOST_W(32), .TAG_EN(1'b0)) u_dut_nt (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .addr_done(addr_done), .rd_en(rd_en_c), .rd_ofs(2'd0),
    .rd_data(rd_data_c), .underflow(uf_c));

  function automatic void summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver side of the scoreboard: expected entries go into per-copy queues.
  function automatic void model_push(input logic [7:0] b, input bit with_addr);
    if (qa.size() < DEPTH) begin qa.push_back({pa | with_addr, b}); pa = 0; end
    else if (with_addr) pa = 1;
    if (qb.size() < DEPTH) begin qb.push_back({pb | with_addr, b}); pb = 0; end
    else if (with_addr) pb = 1;
    if (qc.size() < DEPTH) begin qc.push_back({pc | with_addr, b}); pc = 0; end
    else if (with_addr) pc = 1;
  endfunction

  task automatic push(input logic [7:0] b, input bit with_addr);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b; addr_done = with_addr;
    model_push(b, with_addr);
    @(negedge clk);
    rx_valid = 1'b0; addr_done = 1'b0;
  endtask

  task automatic addr_pulse();
    @(negedge clk);
    addr_done = 1'b1;
    pa = 1; pb = 1; pc = 1;
    @(negedge clk);
    addr_done = 1'b0;
  endtask

  // Monitor side: each read pops the expected item and compares one cycle later.
  task automatic read_a(input logic [1:0] ofs, input string req);
    logic [8:0] e;
    logic [7:0] exp;
    @(negedge clk);
    rd_en_a = 1'b1; rd_ofs_a = ofs;
    exp = 8'h00;
    if (ofs == 2'd0) begin
      if (qa.size() > 0) begin e = qa.pop_front(); exp = e[7:0]; held_a = e[8]; end
      else ufe_a = 1;
    end else if (ofs == 2'd1) begin
      exp = {4'b0000, held_a, 3'b000};
    end
    @(negedge clk);
    rd_en_a = 1'b0;
    check(req, {24'h0, rd_data_a}, {24'h0, exp});
  endtask

  task automatic read_b(input string req);
    logic [8:0] e;
    logic [31:0] exp;
    @(negedge clk);
    rd_en_b = 1'b1;
    exp = 32'h0;
    if (qb.size() > 0) begin e = qb.pop_front(); exp = {20'h0, e[8], 3'b000, e[7:0]}; end
    else ufe_b = 1;
    @(negedge clk);
    rd_en_b = 1'b0;
    check(req, rd_data_b, exp);
  endtask

  task automatic read_c(input string req);
    logic [8:0] e;
    logic [31:0] exp;
    @(negedge clk);
    rd_en_c = 1'b1;
    exp = 32'h0;
    if (qc.size() > 0) begin e = qc.pop_front(); exp = {24'h0, e[7:0]}; end
    else ufe_c = 1;
    @(negedge clk);
    rd_en_c = 1'b0;
    check(req, rd_data_c, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [8:0] e;
    rst_n = 1'b0; rx_valid = 1'b0; rx_byte = 8'h00; addr_done = 1'b0;
    rd_en_a = 1'b0; rd_en_b = 1'b0; rd_en_c = 1'b0; rd_ofs_a = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    check("R9 reset rd_data narrow", {24'h0, rd_data_a}, 32'h0);
    check("R9 reset rd_data wide", rd_data_b, 32'h0);
    check("R8 reset underflow", {29'h0, uf_a, uf_b, uf_c}, 32'h0);

    // R8: empty reads
    read_a(2'd0, "R8 empty read narrow");
    check("R8 underflow narrow", {31'h0, uf_a}, {31'h0, ufe_a});
    read_b("R8 empty read wide");
    check("R8 underflow wide", {31'h0, uf_b}, {31'h0, ufe_b});

    // R2 R5 R6 R7: frame after an address phase
    addr_pulse();
    push(8'hA1, 0); push(8'h22, 0); push(8'h33, 0);
    read_a(2'd0, "R5 first byte data");
    read_a(2'd1, "R6 first byte mark");
    read_a(2'd1, "R6 repeated mark read no pop");
    read_a(2'd2, "R6 offset 2 reads zero");
    read_a(2'd3, "R6 offset 3 reads zero");
    read_a(2'd0, "R7 second byte data");
    read_a(2'd0, "R7 third byte without mark read");
    read_a(2'd1, "R6 sequential byte mark");
    read_b("R3 wide first byte with mark");
    read_b("R3 wide second byte");
    read_b("R3 wide third byte");
    read_c("R4 no mark first byte");
    read_c("R4 no mark second byte");
    read_c("R4 no mark third byte");

    // R2: address pulse in the same cycle as the byte
    push(8'h5C, 1);
    read_a(2'd0, "R2 same-cycle address byte narrow");
    read_a(2'd0, "R8 empty read after data");
    read_a(2'd1, "R6 held mark unchanged by empty read");
    check("R8 underflow stays set", {31'h0, uf_a}, 32'h1);
    read_b("R2 same-cycle address byte wide");
    read_c("R4 same-cycle address byte no mark");

    // R1: overflow drops bytes beyond DEPTH
    addr_pulse();
    for (int i = 0; i < DEPTH + 2; i++) push(8'h10 + 8'(i), 0);
    for (int i = 0; i < DEPTH + 1; i++) read_a(2'd0, "R1 narrow order and drop");
    for (int i = 0; i < DEPTH + 1; i++) read_b("R1 wide order and drop");
    for (int i = 0; i < DEPTH + 1; i++) read_c("R1 no-mark order and drop");

    // R10: simultaneous push and pop
    push(8'h70, 0);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = 8'h71; rd_en_b = 1'b1;
    e = qb.pop_front();
    model_push(8'h71, 0);
    @(negedge clk);
    rx_valid = 1'b0; rd_en_b = 1'b0;
    check("R10 pop during push", rd_data_b, {20'h0, e[8], 3'b000, e[7:0]});
    read_b("R10 pushed byte kept");
    read_a(2'd0, "R10 narrow first");
    read_a(2'd0, "R10 narrow second");
    read_c("R10 no-mark first");
    read_c("R10 no-mark second");

    // R9: output held without reads
    repeat (3) @(negedge clk);
    check("R9 rd_data held", rd_data_c, 32'h71);
    check("R8 underflow flags", {29'h0, uf_a, uf_b, uf_c}, {29'h0, ufe_a, ufe_b, ufe_c});

    done = 1;
    summary();
    $finish;
  end
endmodule